// File: doc/BRIEF.md
# Return Address Stack with Fault Handling

This block holds the return addresses of a small processor core. A call pushes the current program counter, and a return pops the most recent entry. The entry on top of the stack is always on the pop address output. The core reads it in the same cycle as it asserts the pop strobe. A depth output gives the number of live entries. The stack depth and the address width are parameters.

Two conditions are faults: a push onto a full stack and a pop from an empty stack. Each fault sets a sticky status flag. The full flag also sets when a push takes the last free entry, so the core can see the overflow coming. A configuration input decides what else a fault does. When it is high, a fault also raises a one-cycle device-reset request. When it is low, the fault only sets its flag.

The flags stay set until software clears them or a power-on reset occurs. A separate device-reset input empties the stack but keeps the flags. Software can then read, after the restart, why the reset happened.

Top module: `ras_top`

## Requirements
- R1: A push stores `push_addr_i` on top and raises `depth_o` by one. A pop lowers `depth_o` by one. `pop_addr_o` always shows the most recently pushed entry that is still live, so entries come out last-in first-out.
- R2: A push that takes the last free entry sets `full_o` after that clock edge. It does not raise `reset_req_o`.
- R3: A push without a pop while `depth_o` equals DEPTH is an overflow. It writes nothing, `depth_o` and `pop_addr_o` stay unchanged, and `full_o` is set.
- R4: A pop without a push while `depth_o` is 0 is an underflow. `depth_o` stays 0, `pop_addr_o` reads 0, and `unf_o` is set.
- R5: While `rst_on_fault_i` is 1, an overflow or underflow raises `reset_req_o` for exactly one cycle, in the cycle after the faulting clock edge.
- R6: While `rst_on_fault_i` is 0, overflow and underflow still set their flags, but `reset_req_o` stays 0.
- R7: `full_o` and `unf_o` stay set until `clr_full_i` or `clr_unf_i` clears them. When a clear and a new setting event happen in the same cycle, the flag stays set.
- R8: `dev_rst_i` empties the stack (`depth_o` becomes 0) and leaves `full_o` and `unf_o` unchanged. Any push or pop in that cycle is ignored.
- R9: The power-on reset `rst_ni` (active low) clears `depth_o`, `full_o`, `unf_o` and `reset_req_o`.
- R10: A push and a pop in the same cycle on a non-empty stack replace the top entry with `push_addr_i` and keep `depth_o` unchanged. On an empty stack the combined operation changes nothing. Neither case sets a flag or raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| dev_rst_i | input | 1 | Device reset: empties the stack, keeps the flags |
| push_i | input | 1 | Push strobe (call) |
| push_addr_i | input | AW | Address to push |
| pop_i | input | 1 | Pop strobe (return) |
| pop_addr_o | output | AW | Top entry, or 0 when the stack is empty |
| depth_o | output | $clog2(DEPTH+1) | Number of live entries |
| rst_on_fault_i | input | 1 | 1: a fault also requests a device reset |
| clr_full_i | input | 1 | Software clear of the full flag |
| clr_unf_i | input | 1 | Software clear of the underflow flag |
| full_o | output | 1 | Sticky full/overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| reset_req_o | output | 1 | One-cycle device-reset request |

## Verification
Assertions check these properties on every cycle:
- the depth never exceeds DEPTH;
- an overflow leaves the depth and top entry unchanged;
- an underflow keeps the stack empty and the output at zero;
- a fill sets the full flag;
- the flags stay set until cleared;
- a combined push and pop replaces the top;
- every reset request follows a fault made while the configuration bit was high.

Only the bench scenarios can show the rest:
- full last-in first-out ordering across several pushes and pops;
- that a set event wins over a same-cycle clear;
- that a device reset keeps the flags while a power-on reset clears them;
- that the request is a single pulse, with a quiet cycle after it.

// File: rtl/ras_pkg.sv
package ras_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_REPL = 2'd3
  } ras_op_e;

  typedef struct packed {
    logic ovf;   // push onto full stack
    logic unf;   // pop from empty stack
    logic fill;  // push took last free entry
  } ras_evt_t;

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
  import ras_pkg::*;
#(
  parameter int DEPTH = 31,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          dev_rst_i,
  input  logic [PW-1:0] ptr_i,
  output ras_op_e       op_o,
  output ras_evt_t      evt_o
);

  logic is_full, is_empty;

  assign is_full  = (ptr_i == PW'(DEPTH));
  assign is_empty = (ptr_i == '0);

  always_comb begin
    op_o  = OP_NONE;
    evt_o = '0;
    if (!dev_rst_i) begin
      unique case ({push_i, pop_i})
        2'b11: if (!is_empty) op_o = OP_REPL;
        2'b10: begin
          if (is_full) begin
            evt_o.ovf = 1'b1;
          end else begin
            op_o = OP_PUSH;
            evt_o.fill = (ptr_i == PW'(DEPTH - 1));
          end
        end
        2'b01: begin
          if (is_empty) evt_o.unf = 1'b1;
          else          op_o = OP_POP;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ras_store.sv
module ras_store
  import ras_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dev_rst_i,
  input  ras_op_e       op_i,
  input  logic [AW-1:0] wdata_i,
  output logic [PW-1:0] ptr_o,
  output logic [AW-1:0] top_o
);

  logic [PW-1:0] ptr_q;
  logic [AW-1:0] mem_q [DEPTH];
  logic [IW-1:0] rd_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (dev_rst_i) begin
      ptr_q <= '0;
    end else begin
      unique case (op_i)
        OP_PUSH: ptr_q <= ptr_q + PW'(1);
        OP_POP:  ptr_q <= ptr_q - PW'(1);
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic we;
    assign we = ((op_i == OP_PUSH) && (ptr_q == PW'(g))) ||
                ((op_i == OP_REPL) && (ptr_q == PW'(g + 1)));
    always_ff @(posedge clk_i) begin
      if (we) mem_q[g] <= wdata_i;
    end
  end

  assign rd_idx = IW'(ptr_q - PW'(1));
  assign top_o  = (ptr_q == '0) ? '0 : mem_q[rd_idx];
  assign ptr_o  = ptr_q;

  AST_PTR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= PW'(DEPTH)); // R3

endmodule

// File: rtl/ras_fault.sv
module ras_fault
  import ras_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ras_evt_t evt_i,
  input  logic     rst_on_fault_i,
  input  logic     clr_full_i,
  input  logic     clr_unf_i,
  output logic     full_o,
  output logic     unf_o,
  output logic     reset_req_o
);

  logic full_q, unf_q, req_q;

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      unf_q  <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      full_q <= (full_q & ~clr_full_i) | evt_i.ovf | evt_i.fill;
      unf_q  <= (unf_q & ~clr_unf_i) | evt_i.unf;
      req_q  <= rst_on_fault_i & (evt_i.ovf | evt_i.unf);
    end
  end

  assign full_o      = full_q;
  assign unf_o       = unf_q;
  assign reset_req_o = req_q;

  AST_FULL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_q && !clr_full_i) |=> full_q); // R7
  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_q && !clr_unf_i) |=> unf_q); // R7
  AST_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(evt_i.ovf || evt_i.unf)); // R5
  AST_REQ_NEEDS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(rst_on_fault_i)); // R6

endmodule

// File: rtl/ras_top.sv
module ras_top
  import ras_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dev_rst_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] pop_addr_o,
  output logic [PW-1:0] depth_o,
  input  logic          rst_on_fault_i,
  input  logic          clr_full_i,
  input  logic          clr_unf_i,
  output logic          full_o,
  output logic          unf_o,
  output logic          reset_req_o
);

  ras_op_e  op;
  ras_evt_t evt;
  logic [PW-1:0] ptr;

  ras_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .push_i    (push_i),
    .pop_i     (pop_i),
    .dev_rst_i (dev_rst_i),
    .ptr_i     (ptr),
    .op_o      (op),
    .evt_o     (evt)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dev_rst_i (dev_rst_i),
    .op_i      (op),
    .wdata_i   (push_addr_i),
    .ptr_o     (ptr),
    .top_o     (pop_addr_o)
  );

  ras_fault u_fault (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .evt_i          (evt),
    .rst_on_fault_i (rst_on_fault_i),
    .clr_full_i     (clr_full_i),
    .clr_unf_i      (clr_unf_i),
    .full_o         (full_o),
    .unf_o          (unf_o),
    .reset_req_o    (reset_req_o)
  );

  assign depth_o = ptr;

  AST_NO_OVERWRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !dev_rst_i && depth_o == PW'(DEPTH))
      |=> (depth_o == $past(depth_o) && pop_addr_o == $past(pop_addr_o) && full_o)); // R3
  AST_FILL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !dev_rst_i && depth_o == PW'(DEPTH - 1)) |=> full_o); // R2
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !dev_rst_i && depth_o == '0)
      |=> (depth_o == '0 && pop_addr_o == '0 && unf_o)); // R4
  AST_REPLACE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !dev_rst_i && depth_o != '0)
      |=> (depth_o == $past(depth_o) && pop_addr_o == $past(push_addr_i))); // R10

endmodule

// File: tb/tb_ras_top.sv
`timescale 1ns/1ps
module tb_ras_top;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int PW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic dev_rst_i = 0, push_i = 0, pop_i = 0, cfg = 0, clr_full_i = 0, clr_unf_i = 0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] pop_addr_o;
  logic [PW-1:0] depth_o;
  logic full_o, unf_o, reset_req_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ras_top #(.DEPTH(DEPTH), .AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .dev_rst_i(dev_rst_i),
    .push_i(push_i), .push_addr_i(push_addr_i), .pop_i(pop_i),
    .pop_addr_o(pop_addr_o), .depth_o(depth_o), .rst_on_fault_i(cfg),
    .clr_full_i(clr_full_i), .clr_unf_i(clr_unf_i),
    .full_o(full_o), .unf_o(unf_o), .reset_req_o(reset_req_o)
  );

  typedef struct {
    int            depth;
    logic [AW-1:0] top;
    bit            full;
    bit            unf;
    bit            req;
    string         tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [AW-1:0] ref_q[$];
  bit            m_full = 0, m_unf = 0;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected result
  task automatic step(bit ps, bit pp, logic [AW-1:0] a, bit cf, bit cu, bit dr, string tag);
    exp_t e;
    bit ovf = 0, unf = 0, fill = 0;
    @(negedge clk);
    push_i = ps; pop_i = pp; push_addr_i = a;
    clr_full_i = cf; clr_unf_i = cu; dev_rst_i = dr;
    if (dr) ref_q.delete();
    else if (ps && pp) begin
      if (ref_q.size() > 0) ref_q[ref_q.size()-1] = a;
    end else if (ps) begin
      if (ref_q.size() == DEPTH) ovf = 1;
      else begin
        ref_q.push_back(a);
        if (ref_q.size() == DEPTH) fill = 1;
      end
    end else if (pp) begin
      if (ref_q.size() == 0) unf = 1;
      else void'(ref_q.pop_back());
    end
    m_full = (m_full && !cf) || ovf || fill;
    m_unf  = (m_unf && !cu) || unf;
    e.depth = ref_q.size();
    e.top   = (ref_q.size() > 0) ? ref_q[ref_q.size()-1] : '0;
    e.full  = m_full;
    e.unf   = m_unf;
    e.req   = cfg && (ovf || unf);
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0, 0, '0, 0, 0, 0, tag);
  endtask

  // monitor: compare just after each active edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "depth", int'(depth_o), e.depth);
        chk(e.tag, "top", int'(pop_addr_o), int'(e.top));
        chk(e.tag, "full", int'(full_o), int'(e.full));
        chk(e.tag, "unf", int'(unf_o), int'(e.unf));
        chk(e.tag, "req", int'(reset_req_o), int'(e.req));
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 state after power-on reset
    chk("R9", "depth", int'(depth_o), 0);
    chk("R9", "full", int'(full_o), 0);
    chk("R9", "unf", int'(unf_o), 0);
    chk("R9", "req", int'(reset_req_o), 0);
    chk("R9", "top", int'(pop_addr_o), 0);

    cfg = 0;
    step(1, 0, 16'h1111, 0, 0, 0, "R1");
    step(1, 0, 16'h2222, 0, 0, 0, "R1");
    step(1, 0, 16'h3333, 0, 0, 0, "R1");
    step(0, 1, '0, 0, 0, 0, "R1");
    step(1, 1, 16'hAAAA, 0, 0, 0, "R10");   // replace top 2222
    step(0, 1, '0, 0, 0, 0, "R1");
    step(0, 1, '0, 0, 0, 0, "R1");
    step(0, 1, '0, 0, 0, 0, "R4");         // underflow, cfg low
    idle("R6");
    step(1, 1, 16'h5555, 0, 0, 0, "R10");   // combined on empty
    step(0, 0, '0, 0, 1, 0, "R7");          // clear unf
    step(0, 1, '0, 0, 1, 0, "R7");          // set beats clear
    step(0, 0, '0, 0, 1, 0, "R7");
    for (int i = 0; i < DEPTH; i++) step(1, 0, AW'(16'h0100 + i), 0, 0, 0, "R2");
    idle("R2");
    @(negedge clk);
    cfg = 1;
    step(1, 0, 16'hDEAD, 0, 0, 0, "R3");    // overflow with request
    idle("R5");
    step(1, 0, 16'hBEEF, 1, 0, 0, "R7");    // overflow again beats clear
    step(0, 1, '0, 0, 0, 0, "R1");
    step(1, 0, 16'h7777, 0, 0, 1, "R8");    // device reset, push ignored
    idle("R8");
    step(0, 1, '0, 0, 0, 0, "R5");          // underflow with request
    idle("R5");
    cfg = 0;
    step(0, 0, '0, 1, 0, 0, "R7");          // clear full only
    idle("R7");
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9", "full", int'(full_o), 0);
    chk("R9", "unf", int'(unf_o), 0);
    chk("R9", "depth", int'(depth_o), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule